// File: doc/BRIEF.md
# Overcurrent Fault Counter With Hiccup Restart

This block supervises the high-side switch of a synchronous buck stage on a
cycle-by-cycle basis. It receives a strobe at the start of every switching
period, the PWM request, a flag saying the switch node has risen and the raw
output of an overcurrent comparator. A comparator result that survives a
blanking window ends the high-side pulse immediately and hands conduction to the
low-side switch until the next period. Once the converter is regulating, every
period moves a saturating up/down event count one step: up after a period with
an overcurrent, down after a clean one.

When the count fills, the block enters a hiccup sequence. Both gates go to the
fault pattern (high side off, low side on) and the soft-start capacitor is
pulled down. An external comparator reports "capacitor empty" and "capacitor at
threshold". Every empty report takes one step off the count and releases the
capacitor to recharge, and every threshold report pulls it down again. When the
count reaches zero the block leaves the fault and runs a full soft start. An
undervoltage input, and a low soft-start pin outside the hiccup sequence, force
both gates low.

The states are OFF (gates low, count cleared), SOFT (switching, events not
counted), RUN (switching, events counted), DRAIN (fault, capacitor discharging)
and RECHG (fault, capacitor recharging). The transitions are: any state to OFF
on undervoltage; OFF to SOFT when neither undervoltage nor a low pin is present;
SOFT or RUN to OFF on a low pin; SOFT to RUN when the soft start is done; RUN to
DRAIN on a full count; DRAIN to RECHG on an empty report while the count is
above one; DRAIN to SOFT on an empty report while the count is one; RECHG to
DRAIN on a threshold report.

Top module: `oc_hiccup_ctrl`

## Requirements
- R1: After reset both gate outputs, the discharge output and the fault output are 0 and the count reads 0.
- R2: Undervoltage sampled at a clock edge in any state, or a low soft-start pin sampled in SOFT or RUN, drives both gates low after that edge; the count is cleared on the next edge.
- R3: The comparator is ignored until the switch-node flag has been sampled high at BLANK_CYC consecutive edges while the high side is driven (default 4).
- R4: An honoured overcurrent drops the high-side gate in the same cycle and raises the low-side gate; the high side stays off until the next period strobe; the two gates are never high together.
- R5: In RUN, each period strobe adds one to the count if an overcurrent was honoured in the ending period and subtracts one otherwise; the count saturates at 0 and at 7 (three bits by default) and never wraps.
- R6: In SOFT, overcurrents still cut the pulse but period strobes leave the count unchanged; a "soft start done" report moves SOFT to RUN.
- R7: A full count in RUN leads, one edge later, to fault = 1, high side 0, low side 1 and discharge 1.
- R8: In DRAIN an empty report takes one from the count and drops the discharge output; in RECHG a threshold report raises it again; fault stays 1 throughout.
- R9: The empty report that takes the count from 1 to 0 clears the fault and restarts switching in SOFT, so a fault from a full count ends after seven discharges and six recharges.
- R10: During DRAIN and RECHG a low soft-start pin is not treated as shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo_i | input | 1 | Supply below operating level |
| ss_low_i | input | 1 | Soft-start pin below the shutdown level |
| ss_done_i | input | 1 | Soft-start capacitor has reached the regulation threshold |
| ss_empty_i | input | 1 | Soft-start capacitor fully discharged |
| cyc_start_i | input | 1 | One-clock strobe at the start of each switching period |
| pwm_req_i | input | 1 | PWM modulator asks for high-side conduction |
| sw_high_i | input | 1 | Switch node has risen |
| oc_raw_i | input | 1 | Raw overcurrent comparator output |
| hs_gate_o | output | 1 | High-side gate command |
| ls_gate_o | output | 1 | Low-side gate command |
| ss_dis_o | output | 1 | Pull the soft-start capacitor down |
| fault_o | output | 1 | Hiccup fault in progress |
| oc_cnt_o | output | CNT_W | Current overcurrent event count |

## Verification
The critical coincidence is a period strobe that would fill the count arriving in the same cycle as undervoltage. The bench runs six overcurrent periods in RUN, then raises undervoltage just before the seventh strobe edge. The state must go to OFF with gates low and the count cleared one edge later, while fault and discharge never rise; a design that lets the full count win would show the fault pattern instead. A second case checks that the blanking window and the pulse cut act in one cycle: the high side must still be on after BLANK_CYC-1 qualifying edges and off right after the next.

// File: rtl/ocf_pkg.sv
package ocf_pkg;
    typedef enum logic [2:0] {
        HC_OFF   = 3'd0,
        HC_SOFT  = 3'd1,
        HC_RUN   = 3'd2,
        HC_DRAIN = 3'd3,
        HC_RECHG = 3'd4
    } hc_state_t;
endpackage

// File: rtl/oc_blank_gate.sv
// Qualifies the overcurrent comparator: results count only after the switch
// node has been seen high for BLANK_CYC edges while the high side is driven.
module oc_blank_gate #(
    parameter int BLANK_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic sw_high_i,
    input  logic oc_raw_i,
    output logic oc_hit_o
);
    generate
        if (BLANK_CYC == 0) begin : g_noblank
            assign oc_hit_o = arm_i & sw_high_i & oc_raw_i;
        end else begin : g_blank
            localparam int BW = $clog2(BLANK_CYC + 1);
            localparam logic [BW-1:0] BLANK_END = BW'(BLANK_CYC);
            logic [BW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (arm_i && sw_high_i) begin
                    if (cnt_q != BLANK_END) cnt_q <= cnt_q + 1'b1;
                end else begin
                    cnt_q <= '0;
                end
            end

            assign oc_hit_o = arm_i & sw_high_i & oc_raw_i & (cnt_q == BLANK_END);
        end
    endgenerate
endmodule

// File: rtl/oc_updown_sat.sv
// Saturating up/down event counter; clear has priority over increment,
// increment over decrement.
module oc_updown_sat #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             full_o,
    output logic             one_o
);
    localparam logic [CNT_W-1:0] CMAX = '1;
    localparam logic [CNT_W-1:0] CONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
        end else if (dec_i) begin
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign full_o = (cnt_q == CMAX);
    assign one_o  = (cnt_q == CONE);
endmodule

// File: rtl/hiccup_fsm.sv
// Sequences start-up, counted operation and the hiccup discharge loop.
module hiccup_fsm
    import ocf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      uvlo_i,
    input  logic      ss_low_i,
    input  logic      ss_done_i,
    input  logic      ss_empty_i,
    input  logic      cnt_full_i,
    input  logic      cnt_one_i,
    output hc_state_t state_o,
    output logic      sw_en_o,
    output logic      run_o,
    output logic      fault_o,
    output logic      dis_o,
    output logic      drain_o,
    output logic      off_o
);
    hc_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HC_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (uvlo_i) begin
            state_d = HC_OFF;
        end else begin
            unique case (state_q)
                HC_OFF:   if (!ss_low_i) state_d = HC_SOFT;
                HC_SOFT:  begin
                    if (ss_low_i)       state_d = HC_OFF;
                    else if (ss_done_i) state_d = HC_RUN;
                end
                HC_RUN:   begin
                    if (ss_low_i)        state_d = HC_OFF;
                    else if (cnt_full_i) state_d = HC_DRAIN;
                end
                HC_DRAIN: if (ss_empty_i) state_d = cnt_one_i ? HC_SOFT : HC_RECHG;
                HC_RECHG: if (ss_done_i)  state_d = HC_DRAIN;
                default:  state_d = HC_OFF;
            endcase
        end
    end

    always_comb begin
        sw_en_o = 1'b0;
        run_o   = 1'b0;
        fault_o = 1'b0;
        dis_o   = 1'b0;
        drain_o = 1'b0;
        off_o   = 1'b0;
        unique case (state_q)
            HC_OFF:   off_o = 1'b1;
            HC_SOFT:  sw_en_o = 1'b1;
            HC_RUN:   begin sw_en_o = 1'b1; run_o = 1'b1; end
            HC_DRAIN: begin fault_o = 1'b1; dis_o = 1'b1; drain_o = 1'b1; end
            HC_RECHG: fault_o = 1'b1;
            default:  off_o = 1'b1;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/oc_hiccup_ctrl.sv
module oc_hiccup_ctrl
    import ocf_pkg::*;
#(
    parameter int BLANK_CYC = 4,
    parameter int CNT_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uvlo_i,
    input  logic             ss_low_i,
    input  logic             ss_done_i,
    input  logic             ss_empty_i,
    input  logic             cyc_start_i,
    input  logic             pwm_req_i,
    input  logic             sw_high_i,
    input  logic             oc_raw_i,
    output logic             hs_gate_o,
    output logic             ls_gate_o,
    output logic             ss_dis_o,
    output logic             fault_o,
    output logic [CNT_W-1:0] oc_cnt_o
);
    hc_state_t state;
    logic sw_en, run, fault, dis, drain, off;
    logic cnt_full, cnt_one;
    logic cut_q, cut_eff, hs_base, oc_hit;
    logic cnt_inc, cnt_dec;

    hiccup_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .uvlo_i     (uvlo_i),
        .ss_low_i   (ss_low_i),
        .ss_done_i  (ss_done_i),
        .ss_empty_i (ss_empty_i),
        .cnt_full_i (cnt_full),
        .cnt_one_i  (cnt_one),
        .state_o    (state),
        .sw_en_o    (sw_en),
        .run_o      (run),
        .fault_o    (fault),
        .dis_o      (dis),
        .drain_o    (drain),
        .off_o      (off)
    );

    // Pulse cut for the current period; the strobe opens a new period.
    assign cut_eff = cut_q & ~cyc_start_i;
    assign hs_base = sw_en & pwm_req_i & ~cut_eff;

    oc_blank_gate #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (hs_base),
        .sw_high_i (sw_high_i),
        .oc_raw_i  (oc_raw_i),
        .oc_hit_o  (oc_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cut_q <= 1'b0;
        else if (!sw_en)      cut_q <= 1'b0;
        else if (cyc_start_i) cut_q <= oc_hit;
        else                  cut_q <= cut_q | oc_hit;
    end

    assign cnt_inc = run & cyc_start_i & cut_q;
    assign cnt_dec = (run & cyc_start_i & ~cut_q) | (drain & ss_empty_i);

    oc_updown_sat #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (off),
        .inc_i  (cnt_inc),
        .dec_i  (cnt_dec),
        .cnt_o  (oc_cnt_o),
        .full_o (cnt_full),
        .one_o  (cnt_one)
    );

    assign hs_gate_o = hs_base & ~oc_hit;
    assign ls_gate_o = fault | (sw_en & ~hs_gate_o);
    assign ss_dis_o  = dis;
    assign fault_o   = fault;

    logic unused_state;
    assign unused_state = ^state;
endmodule

// File: rtl/oc_hiccup_chk.sv
module oc_hiccup_chk #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             uvlo_i,
    input logic             ss_empty_i,
    input logic             hs_gate_o,
    input logic             ls_gate_o,
    input logic             ss_dis_o,
    input logic             fault_o,
    input logic [CNT_W-1:0] oc_cnt_o
);
    localparam logic [CNT_W-1:0] CMAX = '1;
    localparam logic [CNT_W-1:0] CONE = CNT_W'(1);

    assert_uvlo_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo_i |=> (!hs_gate_o && !ls_gate_o && !fault_o));

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate_o && ls_gate_o));

    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_cnt_o == CMAX && fault_o) |=> (oc_cnt_o >= CMAX - 1'b1));

    assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (oc_cnt_o == $past(oc_cnt_o) || oc_cnt_o == $past(oc_cnt_o) + 1'b1 ||
                  oc_cnt_o + 1'b1 == $past(oc_cnt_o) || oc_cnt_o == '0));

    assert_fault_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (!hs_gate_o && ls_gate_o));

    assert_discharge_in_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ss_dis_o |-> fault_o);

    assert_fault_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !uvlo_i && !(ss_empty_i && oc_cnt_o == CONE)) |=> fault_o);

    assert_exit_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fault_o) && !$past(uvlo_i)) |-> (oc_cnt_o == '0));
endmodule

bind oc_hiccup_ctrl oc_hiccup_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .uvlo_i     (uvlo_i),
    .ss_empty_i (ss_empty_i),
    .hs_gate_o  (hs_gate_o),
    .ls_gate_o  (ls_gate_o),
    .ss_dis_o   (ss_dis_o),
    .fault_o    (fault_o),
    .oc_cnt_o   (oc_cnt_o)
);

// File: tb/oc_hiccup_ctrl_tb.sv
`timescale 1ns/1ps
module oc_hiccup_ctrl_tb;
    localparam int BLANK = 4;
    localparam int CW    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uvlo = 1'b0, ss_low = 1'b1, ss_done = 1'b0, ss_empty = 1'b0;
    logic cyc_start = 1'b0, pwm = 1'b1, sw_high = 1'b0, oc_raw = 1'b0;
    logic hs, ls, dis, fault;
    logic [CW-1:0] cnt;

    always #2.5 clk = ~clk;

    oc_hiccup_ctrl #(.BLANK_CYC(BLANK), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo), .ss_low_i(ss_low),
        .ss_done_i(ss_done), .ss_empty_i(ss_empty), .cyc_start_i(cyc_start),
        .pwm_req_i(pwm), .sw_high_i(sw_high), .oc_raw_i(oc_raw),
        .hs_gate_o(hs), .ls_gate_o(ls), .ss_dis_o(dis), .fault_o(fault),
        .oc_cnt_o(cnt)
    );

    typedef struct {
        string      req;
        logic [6:0] exp;
    } sb_item_t;

    sb_item_t sb_q[$];
    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Monitor: pops each expectation and compares with the live outputs.
    initial begin
        forever begin
            wait (sb_q.size() > 0);
            begin
                sb_item_t it;
                logic [6:0] act;
                it  = sb_q.pop_front();
                act = {hs, ls, dis, fault, cnt};
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s: actual hs/ls/dis/fault/cnt=%b expected=%b",
                             it.req, act, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Driver: pushes the expected outputs, sampled mid-cycle.
    task automatic expect_out(input string req, input logic h, input logic l,
                              input logic d, input logic f, input logic [CW-1:0] c);
        sb_item_t it;
        #1;
        it.req = req;
        it.exp = {h, l, d, f, c};
        sb_q.push_back(it);
        #0.1;
    endtask

    // One switching period; the count moves at the strobe edge.
    task automatic period(input logic oc, input logic uv_at_strobe);
        pwm = 1'b1; sw_high = 1'b1; oc_raw = oc;
        repeat (BLANK + 2) tick();
        pwm = 1'b0; sw_high = 1'b0; oc_raw = 1'b0;
        tick();
        cyc_start = 1'b1; pwm = 1'b1;
        if (uv_at_strobe) uvlo = 1'b1;
        tick();
        cyc_start = 1'b0;
    endtask

    task automatic pulse_done();
        ss_done = 1'b1; tick(); ss_done = 1'b0;
    endtask

    task automatic pulse_empty();
        ss_empty = 1'b1; tick(); ss_empty = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        expect_out("R1 reset", 0, 0, 0, 0, 0);

        // Leave shutdown: SOFT, high side follows the PWM request.
        ss_low = 1'b0;
        tick();
        expect_out("R6 soft entry", 1, 0, 0, 0, 0);

        // Blanking window then pulse cut, inside SOFT.
        sw_high = 1'b1; oc_raw = 1'b1;
        repeat (BLANK - 1) tick();
        expect_out("R3 blanked", 1, 0, 0, 0, 0);
        tick();
        expect_out("R4 cut", 0, 1, 0, 0, 0);
        tick();
        expect_out("R4 cut held", 0, 1, 0, 0, 0);
        sw_high = 1'b0; oc_raw = 1'b0; pwm = 1'b0;
        tick();
        cyc_start = 1'b1; pwm = 1'b1;
        tick();
        cyc_start = 1'b0;
        expect_out("R6 soft not counted", 1, 0, 0, 0, 0);

        pulse_done();
        period(1'b1, 1'b0);
        expect_out("R5 up", 1, 0, 0, 0, 1);
        period(1'b0, 1'b0);
        expect_out("R5 down", 1, 0, 0, 0, 0);
        period(1'b0, 1'b0);
        expect_out("R5 floor", 1, 0, 0, 0, 0);

        for (int i = 0; i < 6; i++) period(1'b1, 1'b0);
        expect_out("R5 six", 1, 0, 0, 0, 6);
        period(1'b1, 1'b0);
        expect_out("R5 full", 1, 0, 0, 0, 7);
        tick();
        expect_out("R7 fault entry", 0, 1, 1, 1, 7);

        ss_low = 1'b1;
        tick();
        expect_out("R10 low pin in drain", 0, 1, 1, 1, 7);

        for (int k = 6; k >= 1; k--) begin
            pulse_empty();
            expect_out("R8 empty step", 0, 1, 0, 1, CW'(k));
            ss_low = 1'b0;
            pulse_done();
            expect_out("R8 redischarge", 0, 1, 1, 1, CW'(k));
        end
        pulse_empty();
        expect_out("R9 restart", 1, 0, 0, 0, 0);

        // Coincidence: count would fill at the same edge undervoltage is seen.
        pulse_done();
        for (int i = 0; i < 6; i++) period(1'b1, 1'b0);
        expect_out("R5 refill", 1, 0, 0, 0, 6);
        period(1'b1, 1'b1);
        expect_out("R2 uvlo wins", 0, 0, 0, 0, 7);
        tick();
        expect_out("R2 count cleared", 0, 0, 0, 0, 0);

        uvlo = 1'b0;
        tick();
        expect_out("R2 recover", 1, 0, 0, 0, 0);
        pulse_done();
        ss_low = 1'b1;
        tick();
        expect_out("R2 low pin in run", 0, 0, 0, 0, 0);

        wait (sb_q.size() == 0);
        #1;
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule